// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

After reset this block owns the command bus of a single-data-rate SDRAM. It issues idle (NOP) cycles for a programmable stabilisation wait with clock enable and every byte mask held high, so the memory keeps its data pins undriven. It then closes all banks and runs the refresh burst and the mode register load in an order fixed by a parameter. Every delay is given in nanoseconds and turned into clock cycles by rounding up.

The mode register word is assembled from four configuration inputs: burst length, burst ordering, CAS latency and write behaviour. Reserved bits are driven to zero. When the last required gap has run out, `init_done` goes high and stays high. From then on the sequencer only drives idle commands, and the normal memory controller can take over the bus.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted and in every cycle before the precharge, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `sd_cke` is 1, every `sd_dqm` bit is 1, bank address and address are 0 and `init_done` is 0.
- R2: The first non-NOP command is precharge-all (0010) with address bit 10 at 1, all other address bits 0 and bank address 0. It is issued in cycle W after reset release, where W = ceil(T_WAIT_NS / clock period) and cycle 0 is the first cycle after release.
- R3: The next command follows the precharge by exactly RP = ceil(T_RP_NS / period) cycles.
- R4: Exactly REFRESH_CNT auto-refresh commands (0001) are issued, each with address 0. Consecutive refreshes are exactly RC = ceil(T_RC_NS / period) cycles apart.
- R5: With MRS_FIRST = 0 the refresh group precedes the mode register load. With MRS_FIRST = 1 the mode register load comes first, and the first refresh follows it by RSC cycles.
- R6: In the mode register load (0000), address bits 2..0 carry the burst length code: 000, 001, 010 or 011 for lengths 1, 2, 4 or 8, and 111 for full page. The reserved input codes 100, 101 and 110 are sent as 011.
- R7: In the mode register load, bit 3 is the burst order (0 sequential, 1 interleaved). Bits 6..4 are 010 when `cfg_cas3` is 0 and 011 when it is 1. Bit 9 is the write mode (0 burst, 1 single). Bits 8, 7, 11 and 10 and the bank address are 0.
- R8: After the mode register load, no command and no `init_done` occurs until RSC = ceil(T_RSC_NS / period) cycles have passed.
- R9: `init_done` rises exactly RC cycles after the last refresh (MRS_FIRST = 1) or RSC cycles after the load (MRS_FIRST = 0). It then stays high, and only NOP is driven.
- R10: Each nanosecond delay is rounded up to whole cycles, with a minimum of one cycle. For example, 68 ns at a 10 ns clock gives 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset; the sequence restarts on release |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_interleave | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cfg_cas3 | input | 1 | CAS latency select: 0 latency 2, 1 latency 3 |
| cfg_single_write | input | 1 | Write mode: 0 burst, 1 single |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Byte masks |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address / mode word |
| init_done | output | 1 | High once initialization is complete |

## Verification
Two events can land in the same cycle at the end of the sequence: the expiry of the last command gap and the rise of `init_done`. With MRS_FIRST = 0 that gap is RSC after the mode load. With MRS_FIRST = 1 it is RC after the final refresh. Both parameter orders run side by side from the same inputs across all 64 combinations of mode inputs. Each output is compared in every cycle against a schedule worked out arithmetically from the rounded cycle counts. This exposes any command that comes one cycle early, any `init_done` that overlaps the last gap, and any idle cycle that drops out.

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_WAIT_NS     = 200000,
  parameter int T_RP_NS       = 20,
  parameter int T_RC_NS       = 68,
  parameter int T_RSC_NS      = 16,
  parameter int REFRESH_CNT   = 8,
  parameter bit MRS_FIRST     = 1'b0,
  parameter int DQM_W         = 8,
  parameter int BA_W          = 2,
  parameter int ADDR_W        = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic              cfg_cas3,
  input  logic              cfg_single_write,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int WAIT_CYC = ns2cyc(T_WAIT_NS);
  localparam int RP_CYC   = ns2cyc(T_RP_NS);
  localparam int RC_CYC   = ns2cyc(T_RC_NS);
  localparam int RSC_CYC  = ns2cyc(T_RSC_NS);
  localparam int MAX_GAP  = (RP_CYC > RC_CYC) ? ((RP_CYC > RSC_CYC) ? RP_CYC : RSC_CYC)
                                              : ((RC_CYC > RSC_CYC) ? RC_CYC : RSC_CYC);
  localparam int MAX_CYC  = (WAIT_CYC > MAX_GAP) ? WAIT_CYC : MAX_GAP;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int STEP_W   = $clog2(REFRESH_CNT + 1) + 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(REFRESH_CNT);

  typedef enum logic [1:0] {PH_PRE, PH_STEP, PH_DONE} phase_t;
  typedef enum logic [3:0] {
    C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000
  } cmd_t;

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] step;
  cmd_t              cmd;
  logic [CNT_W-1:0]  gap;
  logic              fire;
  logic              mrs_step;
  logic [2:0]        bl_code;
  logic [11:0]       mode_word;

  assign fire     = (cnt == '0) && (phase != PH_DONE);
  assign mrs_step = MRS_FIRST ? (step == '0) : (step == LAST_STEP);

  always_comb begin
    cmd = C_NOP;
    if (fire) begin
      if (phase == PH_PRE) cmd = C_PRE;
      else if (mrs_step)   cmd = C_MRS;
      else                 cmd = C_REF;
    end
  end

  always_comb begin
    case (cmd)
      C_PRE:   gap = CNT_W'(RP_CYC);
      C_MRS:   gap = CNT_W'(RSC_CYC);
      default: gap = CNT_W'(RC_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_PRE;
      cnt   <= CNT_W'(WAIT_CYC);
      step  <= '0;
    end else if (fire) begin
      cnt <= gap - 1'b1;
      if (phase == PH_PRE) begin
        phase <= PH_STEP;
        step  <= '0;
      end else if (step == LAST_STEP) begin
        phase <= PH_DONE;
      end else begin
        step <= step + 1'b1;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    case (cfg_burst_len)
      3'b100, 3'b101, 3'b110: bl_code = 3'b011;
      default:                bl_code = cfg_burst_len;
    endcase
  end

  assign mode_word = {2'b00, cfg_single_write, 2'b00,
                      cfg_cas3 ? 3'b011 : 3'b010, cfg_interleave, bl_code};

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke    = 1'b1;
  assign sd_dqm    = '1;
  assign sd_ba     = '0;
  assign sd_addr   = (cmd == C_PRE) ? ADDR_W'(12'h400) :
                     (cmd == C_MRS) ? ADDR_W'(mode_word) : '0;
  assign init_done = (phase == PH_DONE) && (cnt == '0);

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int DQM_W       = 8,
  parameter int BA_W        = 2,
  parameter int ADDR_W      = 12,
  parameter int WAIT_CYC    = 1,
  parameter int RP_CYC      = 1,
  parameter int RC_CYC      = 1,
  parameter int RSC_CYC     = 1,
  parameter int REFRESH_CNT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cke,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done
);
  localparam logic [3:0] K_NOP = 4'b0111, K_PRE = 4'b0010, K_REF = 4'b0001, K_MRS = 4'b0000;

  logic [3:0]  cmd, last_cmd;
  logic [31:0] since;
  logic        seen_cmd;
  int          refs;
  logic        mrs_seen;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since    <= '0;
      last_cmd <= K_NOP;
      seen_cmd <= 1'b0;
      refs     <= 0;
      mrs_seen <= 1'b0;
    end else begin
      if (cmd != K_NOP) begin
        since    <= 32'd1;
        last_cmd <= cmd;
        seen_cmd <= 1'b1;
      end else if (since != '1) begin
        since <= since + 1'b1;
      end
      if (cmd == K_REF) refs <= refs + 1;
      if (cmd == K_MRS) mrs_seen <= 1'b1;
    end
  end

  assert_cke_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke && (&sd_dqm));
  assert_first_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != K_NOP && !seen_cmd) |-> (cmd == K_PRE && since >= 32'(WAIT_CYC)));
  assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_PRE) |-> (sd_addr[10] && sd_ba == '0));
  assert_trp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != K_NOP && seen_cmd && last_cmd == K_PRE) |-> since >= 32'(RP_CYC));
  assert_trc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd != K_NOP || init_done) && seen_cmd && last_cmd == K_REF) |-> since >= 32'(RC_CYC));
  assert_trsc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd != K_NOP || init_done) && seen_cmd && last_cmd == K_MRS) |-> since >= 32'(RSC_CYC));
  assert_bl_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_MRS) |-> (sd_addr[2:0] inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111}));
  assert_mode_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_MRS) |-> (sd_ba == '0 && sd_addr[8:7] == 2'b00 && sd_addr[11:10] == 2'b00
                        && sd_addr[6:4] inside {3'b010, 3'b011}));
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == K_NOP && refs == REFRESH_CNT && mrs_seen));
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .DQM_W(DQM_W), .BA_W(BA_W), .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC),
  .RP_CYC(RP_CYC), .RC_CYC(RC_CYC), .RSC_CYC(RSC_CYC), .REFRESH_CNT(REFRESH_CNT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_dqm(sd_dqm), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
  .sd_addr(sd_addr), .init_done(init_done)
);

// File: tb/sdram_powerup_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_powerup_seq_tb_top;
  localparam int W   = 100;  // 1000 ns at 10 ns
  localparam int RP  = 2;    // 20 ns
  localparam int RC  = 7;    // R10: 68 ns rounds up to 7 cycles
  localparam int RSC = 2;    // 16 ns rounds up to 2 cycles
  localparam int N   = 8;
  localparam int RUN = W + RP + N * RC + RSC + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bl = '0;
  logic bt = 0, cl3 = 0, wm = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic cke_a, cs_a, ras_a, cas_a, we_a, done_a;
  logic [7:0] dqm_a; logic [1:0] ba_a; logic [11:0] addr_a;
  logic cke_b, cs_b, ras_b, cas_b, we_b, done_b;
  logic [7:0] dqm_b; logic [1:0] ba_b; logic [11:0] addr_b;

  always #5 clk = ~clk;

  sdram_powerup_seq #(.T_WAIT_NS(1000), .MRS_FIRST(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_interleave(bt), .cfg_cas3(cl3),
    .cfg_single_write(wm), .sd_cke(cke_a), .sd_dqm(dqm_a), .sd_cs_n(cs_a), .sd_ras_n(ras_a),
    .sd_cas_n(cas_a), .sd_we_n(we_a), .sd_ba(ba_a), .sd_addr(addr_a), .init_done(done_a));

  sdram_powerup_seq #(.T_WAIT_NS(1000), .MRS_FIRST(1'b1)) dut_m (
    .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_interleave(bt), .cfg_cas3(cl3),
    .cfg_single_write(wm), .sd_cke(cke_b), .sd_dqm(dqm_b), .sd_cs_n(cs_b), .sd_ras_n(ras_b),
    .sd_cas_n(cas_b), .sd_we_n(we_b), .sd_ba(ba_b), .sd_addr(addr_b), .init_done(done_b));

  function automatic logic [11:0] mode_exp();
    logic [2:0] b;
    b = (bl >= 3'd4 && bl <= 3'd6) ? 3'd3 : bl;
    return {2'b00, wm, 2'b00, cl3 ? 3'b011 : 3'b010, bt, b};
  endfunction

  function automatic logic [20:0] obs(input bit mf);
    if (mf) return {cs_b, ras_b, cas_b, we_b, ba_b, addr_b, cke_b, &dqm_b, done_b};
    return {cs_a, ras_a, cas_a, we_a, ba_a, addr_a, cke_a, &dqm_a, done_a};
  endfunction

  task automatic check(input string tag, input bit mf, input int k, input logic [20:0] exp);
    logic [20:0] act;
    act = obs(mf);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s order=%0d cycle=%0d cfg=%0d/%0d/%0d/%0d actual=%h expected=%h",
               tag, mf, k, bl, bt, cl3, wm, act, exp);
    end
  endtask

  task automatic check_cycle(input bit mf, input int k);
    int first, mrs, done_at, rel;
    logic [3:0] ec; logic [11:0] ea; string tag;
    first = W + RP;
    mrs     = mf ? first : first + N * RC;
    done_at = mf ? first + RSC + N * RC : mrs + RSC;
    ec = 4'b0111; ea = '0; tag = mf ? "R5" : "R4";
    if (k < W) tag = "R1";
    else if (k == W) begin ec = 4'b0010; ea = 12'h400; tag = "R2"; end
    else if (k < first) tag = "R3";
    else if (k == mrs) begin ec = 4'b0000; ea = mode_exp(); tag = (k == first) ? "R5" : "R6 R7"; end
    else if (k > mrs && k < mrs + RSC) tag = "R8";
    else if (k >= done_at) tag = "R9";
    else begin
      rel = k - (mf ? first + RSC : first);
      if (rel >= 0 && rel % RC == 0 && rel / RC < N) begin
        ec = 4'b0001;
        tag = (rel == 0 && !mf) ? "R3" : (rel == RC) ? "R10" : "R4";
      end
    end
    check(tag, mf, k, {ec, 2'b00, ea, 1'b1, 1'b1, (k >= done_at) ? 1'b1 : 1'b0});
  endtask

  initial begin
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      rst_n = 1'b0;
      bl = c[2:0]; bt = c[3]; cl3 = c[4]; wm = c[5];
      @(negedge clk); #1;
      check("R1", 1'b0, -1, {4'b0111, 2'b00, 12'h000, 1'b1, 1'b1, 1'b0});
      check("R1", 1'b1, -1, {4'b0111, 2'b00, 12'h000, 1'b1, 1'b1, 1'b0});
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < RUN; k++) begin
        #1;
        check_cycle(1'b0, k);
        check_cycle(1'b1, k);
        @(negedge clk);
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule